// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block is the slave-side command engine of a byte-wide serial EEPROM. Chip select, serial clock and serial data in are sampled in the system clock domain. The engine reads an 8-bit opcode, most significant bit first. Memory commands then take a 16-bit address. Two paths follow from the opcode:

- **Read.** The engine streams bytes from its storage array on the serial output. It shifts a new bit out after every serial clock falling edge.
- **Write.** The engine collects data bytes into a page latch.

When select rises cleanly after a complete data byte, the latch is copied into the array. A timed internal write cycle then starts.

While that cycle runs:

- Array reads are refused.
- Further write commands are ignored.
- The status byte can still be polled. It carries the busy flag in bit 0 and the write-enable latch in bit 1.

The write-enable latch is set or cleared by one-byte commands. These take effect only when select rises straight after their eighth bit. The latch is also cleared at the end of every internal write cycle.

Top module: `spi_ee_engine`

## Requirements
- R1: Opcodes are taken MSB first: 0x03 read, 0x02 write, 0x06 set write enable, 0x04 clear write enable, 0x05 read status. Any other opcode, including 0x01, is consumed with no effect. A read delivers the byte at the 16-bit address, MSB first, starting after the falling edge that follows the 24th rising edge.
- R2: A read continues byte after byte with the address incremented each time; after address 0x3FF it continues at 0x000.
- R3: A write is accepted only while the write-enable latch is set. Opcode 0x06 sets the latch only when select rises right after its 8th bit; any further clock edge before that cancels it.
- R4: Write data runs within one 16-byte page: after offset 15 it continues at offset 0 of the same page and overwrites bytes written earlier; the next page stays untouched.
- R5: The array is updated only when select rises after at least one whole data byte and on a byte boundary. A write with no data bytes, or with trailing partial bits, changes nothing and leaves the write-enable latch as it was.
- R6: The status byte is {6'b0, wel, busy}. During the internal write cycle it reads busy=1, and an array read leaves the output disabled for the whole transfer.
- R7: A write command issued during the internal write cycle is ignored, even with the write-enable latch set.
- R8: The write-enable latch is cleared when the internal write cycle ends, and by opcode 0x04 completed with select rising after 8 bits.
- R9: The output enable is low after reset and falls once select goes high.
- R10: After reset, no command is taken until select has been seen high and then low.
- R11: Address bits above bit 9 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock (mode 0) |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |

## Verification
Two functions can fall in the same system-clock cycle: the end of the internal write cycle, and the capture of a status byte for shifting. Both the busy flag and the write-enable latch change at that edge. The bench provokes this by holding one status read open across the whole write cycle and judging every streamed byte: each must be either 0x03 or 0x00, never a mixed value. The stream must also end on 0x00.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_WDATA, ST_RDATA, ST_SR, ST_OPDONE, ST_SKIP
  } eng_st_e;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  // status byte layout: bit0 busy, bit1 write-enable latch
  function automatic logic [7:0] status_byte(input logic busy, input logic wel);
    return {6'b0, wel, busy};
  endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_rise,
  output logic cs_fall,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  // select history resets low so a high select after reset shows as a rise
  logic [2:0] cs_q;
  logic [2:0] sck_q;
  logic [1:0] si_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= '0;
      sck_q <= '0;
      si_q  <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      si_q  <= {si_q[0], si};
    end
  end

  assign cs_rise  = cs_q[1] & ~cs_q[2];
  assign cs_fall  = ~cs_q[1] & cs_q[2];
  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign si_s     = si_q[1];
endmodule

// File: rtl/spi_ee_page_latch.sv
module spi_ee_page_latch #(
  parameter int PAGE = 16,
  localparam int PW = $clog2(PAGE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [PW-1:0]     wofs,
  input  logic [7:0]        wdata,
  output logic [PAGE*8-1:0] data,
  output logic [PAGE-1:0]   mask
);
  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data[g*8 +: 8] <= '0;
        mask[g]        <= 1'b0;
      end else if (clr) begin
        mask[g] <= 1'b0;
      end else if (we && wofs == PW'(g)) begin
        data[g*8 +: 8] <= wdata;
        mask[g]        <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int DEPTH = 1024,
  parameter int PAGE  = 16,
  localparam int AW  = $clog2(DEPTH),
  localparam int PW  = $clog2(PAGE),
  localparam int PGW = AW - PW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     raddr,
  output logic [7:0]        rdata,
  input  logic              commit,
  input  logic [PGW-1:0]    cpage,
  input  logic [PAGE*8-1:0] cdata,
  input  logic [PAGE-1:0]   cmask
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int j = 0; j < PAGE; j++)
        if (cmask[j]) mem[{cpage, PW'(j)}] <= cdata[j*8 +: 8];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
  parameter int TWC = 6000,
  localparam int CW = $clog2(TWC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam logic [CW-1:0] LOAD = CW'(TWC - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= LOAD;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/spi_ee_engine.sv
module spi_ee_engine
  import spi_ee_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int PAGE  = 16,
  parameter int TWC   = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = $clog2(PAGE);
  localparam int PGW = AW - PW;
  localparam logic [PW-1:0] ONE_P = 1;
  localparam logic [AW-1:0] ONE_A = 1;

  function automatic logic [AW-1:0] in_page_next(input logic [AW-1:0] a);
    return {a[AW-1:PW], a[PW-1:0] + ONE_P};
  endfunction

  logic cs_rise, cs_fall, sck_rise, sck_fall, si_s;

  spi_ee_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
  );

  eng_st_e       state;
  logic [2:0]    bitcnt;
  logic [6:0]    sh;
  logic [AW-1:0] addr_r;
  logic          addr_second;
  logic          is_rd;
  logic          have_data;
  logic          pend_set;
  logic [2:0]    ocnt;
  logic [6:0]    osh;
  logic          so_r, oe_r;
  logic          wel;

  // named internal events, used by the bound checker
  logic busy, wcyc_done, commit_evt, in_sr;
  logic [7:0] byte_in, mem_rdata, out_byte;
  logic shifting, last_bit, wr_ok, lat_clr, lat_we;
  logic [PAGE*8-1:0] lat_data;
  logic [PAGE-1:0]   lat_mask;

  assign byte_in    = {sh, si_s};
  assign shifting   = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_WDATA);
  assign last_bit   = sck_rise && shifting && (bitcnt == 3'd7);
  assign wr_ok      = !busy && wel;
  assign lat_clr    = last_bit && (state == ST_CMD) && (byte_in == OP_WRITE) && wr_ok;
  assign lat_we     = last_bit && (state == ST_WDATA);
  assign commit_evt = cs_rise && (state == ST_WDATA) && (bitcnt == 3'd0) && have_data;
  assign in_sr      = (state == ST_SR);
  assign out_byte   = in_sr ? status_byte(busy, wel) : mem_rdata;

  spi_ee_page_latch #(.PAGE(PAGE)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr(lat_clr), .we(lat_we),
    .wofs(addr_r[PW-1:0]), .wdata(byte_in),
    .data(lat_data), .mask(lat_mask)
  );

  spi_ee_array #(.DEPTH(DEPTH), .PAGE(PAGE)) u_array (
    .clk(clk), .rst_n(rst_n), .raddr(addr_r), .rdata(mem_rdata),
    .commit(commit_evt), .cpage(addr_r[AW-1:PW]),
    .cdata(lat_data), .cmask(lat_mask)
  );

  spi_ee_wtimer #(.TWC(TWC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit_evt), .busy(busy), .done(wcyc_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (wcyc_done) begin
      wel <= 1'b0;
    end else if (cs_rise && state == ST_OPDONE) begin
      wel <= pend_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bitcnt      <= '0;
      sh          <= '0;
      addr_r      <= '0;
      addr_second <= 1'b0;
      is_rd       <= 1'b0;
      have_data   <= 1'b0;
      pend_set    <= 1'b0;
      ocnt        <= '0;
      osh         <= '0;
      so_r        <= 1'b0;
      oe_r        <= 1'b0;
    end else if (cs_rise) begin
      state <= ST_IDLE;
      oe_r  <= 1'b0;
    end else if (cs_fall) begin
      state       <= ST_CMD;
      bitcnt      <= '0;
      ocnt        <= '0;
      addr_second <= 1'b0;
      have_data   <= 1'b0;
    end else begin
      if (sck_rise && shifting) begin
        bitcnt <= bitcnt + 3'd1;
        sh     <= byte_in[6:0];
      end
      if (sck_rise && state == ST_ADDR)
        addr_r <= {addr_r[AW-2:0], si_s};
      if (sck_rise && state == ST_OPDONE)
        state <= ST_SKIP;
      if (last_bit) begin
        case (state)
          ST_CMD: begin
            case (byte_in)
              OP_READ:  begin state <= ST_ADDR; is_rd <= 1'b1; end
              OP_WRITE: begin
                if (wr_ok) begin state <= ST_ADDR; is_rd <= 1'b0; end
                else       state <= ST_SKIP;
              end
              OP_WREN:  begin state <= ST_OPDONE; pend_set <= 1'b1; end
              OP_WRDI:  begin state <= ST_OPDONE; pend_set <= 1'b0; end
              OP_RDSR:  state <= ST_SR;
              default:  state <= ST_SKIP;
            endcase
          end
          ST_ADDR: begin
            if (!addr_second)  addr_second <= 1'b1;
            else if (is_rd)    state <= busy ? ST_SKIP : ST_RDATA;
            else               state <= ST_WDATA;
          end
          ST_WDATA: begin
            addr_r    <= in_page_next(addr_r);
            have_data <= 1'b1;
          end
          default: ;
        endcase
      end
      if (sck_fall && (state == ST_RDATA || state == ST_SR)) begin
        oe_r <= 1'b1;
        ocnt <= ocnt + 3'd1;
        if (ocnt == 3'd0) begin
          so_r <= out_byte[7];
          osh  <= out_byte[6:0];
          if (state == ST_RDATA) addr_r <= addr_r + ONE_A;
        end else begin
          so_r <= osh[6];
          osh  <= {osh[5:0], 1'b0};
        end
      end
    end
  end

  assign so    = so_r;
  assign so_oe = oe_r;
endmodule

// File: rtl/spi_ee_engine_chk.sv
module spi_ee_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_rise,
  input logic so_oe,
  input logic in_sr,
  input logic busy,
  input logic wel,
  input logic commit_evt,
  input logic wcyc_done
);
  // R9
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !so_oe);

  // R6
  busy_read_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && so_oe) |-> in_sr);

  // R3
  commit_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> wel);

  // R7
  no_commit_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> !busy);

  // R5
  commit_starts_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> busy);

  // R8
  cycle_end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc_done |=> (!busy && !wel));
endmodule

bind spi_ee_engine spi_ee_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .so_oe(so_oe), .in_sr(in_sr),
  .busy(busy), .wel(wel), .commit_evt(commit_evt), .wcyc_done(wcyc_done)
);

// File: tb/tb_spi_ee_engine.sv
module tb_spi_ee_engine;
  localparam int TWC = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic so, so_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] rbuf [0:63];
  logic       obuf [0:63];

  always #4 clk = ~clk;

  spi_ee_engine #(.TWC(TWC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe)
  );

  // {address16, data8}
  localparam logic [23:0] VEC [6] = '{
    24'h0005_5A, 24'h03FF_C3, 24'h0000_3C,
    24'h0123_81, 24'h02F0_7E, 24'h0100_00
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic xn(input logic [7:0] tx, input int nb, output logic [7:0] rx, output logic oe);
    rx = '0;
    oe = 1'b1;
    for (int i = 7; i > 7 - nb; i--) begin
      si = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = so;
      oe = oe & so_oe;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic one_op(input logic [7:0] op);
    logic [7:0] r; logic o;
    cs_lo(); xn(op, 8, r, o); cs_hi();
  endtask

  task automatic rd_mem(input logic [15:0] a, input int n);
    logic [7:0] r; logic o;
    cs_lo();
    xn(8'h03, 8, r, o); xn(a[15:8], 8, r, o); xn(a[7:0], 8, r, o);
    for (int k = 0; k < n; k++) begin
      xn(8'h00, 8, r, o);
      rbuf[k] = r; obuf[k] = o;
    end
    cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic o;
    cs_lo();
    xn(8'h05, 8, s, o); xn(8'h00, 8, s, o);
    cs_hi();
  endtask

  task automatic wr_mem(input logic [15:0] a, input int n, input logic [7:0] base, input int extra);
    logic [7:0] r; logic o;
    cs_lo();
    xn(8'h02, 8, r, o); xn(a[15:8], 8, r, o); xn(a[7:0], 8, r, o);
    for (int k = 0; k < n; k++) xn(base + 8'(k), 8, r, o);
    if (extra > 0) xn(8'hFF, extra, r, o);
    cs_hi();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [7:0] r;
    logic o;
    logic bad;
    int n00;
    repeat (10) @(negedge clk);
    // R9: reset state
    chk("R9 oe after reset", {7'b0, so_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: select held low from reset, command must be ignored
    xn(8'h05, 8, r, o); xn(8'h00, 8, r, o);
    chk("R10 no response without select edge", {7'b0, o}, 8'h00);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);

    // R6: idle status
    rdsr(s);
    chk("R6 idle status", s, 8'h00);

    // R1: table of byte writes and readback
    for (int k = 0; k < 6; k++) begin
      one_op(8'h06);
      wr_mem(VEC[k][23:8], 1, VEC[k][7:0], 0);
      repeat (TWC + 100) @(negedge clk);
      rd_mem(VEC[k][23:8], 1);
      chk("R1 readback", rbuf[0], VEC[k][7:0]);
      chk("R1 oe during read", {7'b0, obuf[0]}, 8'h01);
    end

    // R2: sequential read wrapping from top of array
    rd_mem(16'h03FF, 3);
    chk("R2 top byte", rbuf[0], 8'hC3);
    chk("R2 wrap to zero", rbuf[1], 8'h3C);
    chk("R2 next after wrap", rbuf[2], 8'hFF);

    // R11: high address bits ignored
    rd_mem(16'hFC05, 1);
    chk("R11 aliased read", rbuf[0], 8'h5A);

    // R3: write without enable is dropped
    wr_mem(16'h0060, 1, 8'h12, 0);
    repeat (TWC + 100) @(negedge clk);
    rd_mem(16'h0060, 1);
    chk("R3 write without enable", rbuf[0], 8'hFF);
    // R3: enable followed by an extra bit does not set the latch
    cs_lo(); xn(8'h06, 8, r, o); xn(8'hFF, 1, r, o); cs_hi();
    rdsr(s);
    chk("R3 enable with extra bit", s, 8'h00);

    // R8: clear-enable command
    one_op(8'h06);
    rdsr(s);
    chk("R8 enable set", s, 8'h02);
    one_op(8'h04);
    rdsr(s);
    chk("R8 enable cleared by opcode", s, 8'h00);

    // R1: WRSR opcode consumed without effect
    one_op(8'h01);
    rdsr(s);
    chk("R1 unsupported opcode", s, 8'h00);

    // R4: page wrap, 18 bytes from offset 0 of page 0x020
    one_op(8'h06);
    wr_mem(16'h0020, 18, 8'hA0, 0);
    repeat (TWC + 100) @(negedge clk);
    rd_mem(16'h0020, 17);
    bad = 1'b0;
    for (int k = 0; k < 16; k++)
      if (rbuf[k] !== ((k < 2) ? 8'hB0 + 8'(k) : 8'hA0 + 8'(k))) bad = 1'b1;
    chk("R4 page content wrapped", {7'b0, bad}, 8'h00);
    chk("R4 offset0 overwritten", rbuf[0], 8'hB0);
    chk("R4 next page untouched", rbuf[16], 8'hFF);

    // R5: no data bytes, then trailing partial bits
    one_op(8'h06);
    wr_mem(16'h0040, 0, 8'h00, 0);
    rdsr(s);
    chk("R5 no data keeps enable, no cycle", s, 8'h02);
    wr_mem(16'h0040, 1, 8'h99, 3);
    rdsr(s);
    chk("R5 partial byte no cycle", s, 8'h02);
    rd_mem(16'h0040, 1);
    chk("R5 array unchanged", rbuf[0], 8'hFF);
    one_op(8'h04);

    // R6/R7: behaviour during the internal cycle
    one_op(8'h06);
    wr_mem(16'h0050, 1, 8'h11, 0);
    rdsr(s);
    chk("R6 busy status", s, 8'h03);
    rd_mem(16'h0050, 1);
    chk("R6 read refused while busy", {7'b0, obuf[0]}, 8'h00);
    one_op(8'h06);
    wr_mem(16'h0051, 1, 8'h22, 0);
    // cycle end while a status stream is open
    cs_lo(); xn(8'h05, 8, r, o);
    bad = 1'b0; n00 = 0;
    for (int k = 0; k < 60 && n00 == 0; k++) begin
      xn(8'h00, 8, r, o);
      if (r == 8'h00) n00 = 1;
      else if (r != 8'h03) bad = 1'b1;
    end
    cs_hi();
    chk("R8 stream bytes consistent", {7'b0, bad}, 8'h00);
    chk("R8 stream reached idle", 8'(n00), 8'h01);
    rdsr(s);
    chk("R8 enable cleared at cycle end", s, 8'h00);
    rd_mem(16'h0050, 2);
    chk("R6 committed byte", rbuf[0], 8'h11);
    chk("R7 write during cycle ignored", rbuf[1], 8'hFF);

    // R9: output disabled after select high
    chk("R9 oe idle", {7'b0, so_oe}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule